// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a byte-addressed real-time clock register file. A one-cycle pulse arriving once per second advances a packed-BCD calendar made of seconds, minutes, hours (24-hour form), day of week, date, month, year and century. Date rollover follows the month length, and February has 29 days whenever the BCD year is divisible by four. A four-field alarm comparator, covering seconds, minutes, hours and date, sets an interrupt flag. A host reaches every register through a synchronous port with an 8-bit address, 8-bit data, a read strobe and a write strobe. Read data is combinational from the address.

Time is counted in an internal shadow. The host sees a visible copy of it. Clearing the transfer-enable bit freezes that copy so that a multi-byte read or write stays coherent. A three-state machine controls the copy:
- LIVE: the copy follows the shadow every cycle. Host time writes go straight to the shadow.
- FROZEN: the copy holds. Host time writes land in the copy and mark the field dirty.
- COMMIT: lasts one cycle. Dirty fields are loaded into the shadow.

The machine has three transitions:
- LIVE to FROZEN on a write of control with bit 7 clear.
- FROZEN to COMMIT on a write of control with bit 7 set.
- COMMIT to LIVE unconditionally.

The shadow never stops counting, so no second is lost while frozen.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, addresses 0x0 to 0x7 read 00, 00, 00, 01, 01, 01, 00, 20 (seconds, minutes, hours, day of week, date, month, year, century). Alarms 0x8 to 0xB read 00, status 0xE reads 00, control 0xF reads 0x80, and irq is low.
- R2: Time writes keep only each field's valid bits: 7 for seconds (0x0) and minutes (0x1), 6 for hours (0x2) and date (0x4), 3 for day of week (0x3), 8 for year (0x6) and century (0x7). Addresses above 0xF read as 0.
- R3: On a tick, seconds 59 wraps to 00 and carries into minutes, minutes 59 wraps to 00 and carries into hours, and hours 23 wraps to 00 and carries into the date.
- R4: A date carry wraps the date to 01 after the month's last day (30 or 31 days, February 28, or 29 in a leap year) and advances day of week 7 to 1. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and advances the century.
- R5: Month register bits 7:5 hold the value written and are never altered by counting.
- R6: While control bit 7 (transfer enable) is 0, time reads stay constant across ticks.
- R7: When transfer enable returns to 1, fields written during the freeze take the written value. All other fields show the count that continued during the freeze. Time reads reflect this from the second cycle after that control write.
- R8: Alarm registers 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (date) use bit 7 as a don't-care mask. On a tick, status bit 0 is set when every unmasked field equals the post-tick count, and only then.
- R9: With all four alarm masks set, status bit 0 is set on every tick.
- R10: Reading status 0xE returns the flag in bit 0 and clears it. If the flag is set in the same cycle as the read, the set wins.
- R11: irq equals status bit 0 AND control bit 3.
- R12: A time write made while LIVE in the same cycle as a tick stores the written byte. The other fields advance using the carries of the pre-write count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect: clears the flag at 0xE) |
| rdata | output | 8 | Combinational read data for addr |
| irq | output | 1 | Active-high interrupt |

## Verification
The range assertions on the seconds and hours shadow assume the host only writes valid BCD within each field's range. A write that is out of range after masking would leave the counter outside its sequence. The wrap and month-control assertions apply only to cycles with no host time write and no commit. Every write in the directed stimulus therefore carries a legal BCD value, and the tests exercising masking set only bits that masking removes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_LIVE   = 2'd0,
        ST_FROZEN = 2'd1,
        ST_COMMIT = 2'd2
    } xfer_state_t;

    localparam int NUM_TIME  = 8;
    localparam int NUM_ALARM = 4;

    // index 7 = century ... index 0 = seconds
    localparam logic [NUM_TIME-1:0][7:0] TIME_RST =
        {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    function automatic logic [7:0] time_mask(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: return 8'h7F;
            3'd2, 3'd4: return 8'h3F;
            3'd3:       return 8'h07;
            default:    return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = 7'({3'b0, yr[7:4]} * 7'd10) + {3'b0, yr[3:0]};
        case (mon)
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            5'h02:   return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            default: return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      wr,
    input  logic [2:0]                wr_idx,
    input  logic [7:0]                wr_val,
    input  logic [NUM_TIME-1:0]       ovl_en,
    input  logic [NUM_TIME-1:0][7:0]  ovl_val,
    output logic [NUM_TIME-1:0][7:0]  cnt,
    output logic [NUM_TIME-1:0][7:0]  cnt_tick,
    output logic [NUM_TIME-1:0][7:0]  cnt_next
);

    logic c;

    always_comb begin
        cnt_tick = cnt;
        c = tick;
        if (c) begin
            if (cnt[0] >= 8'h59) cnt_tick[0] = 8'h00;
            else begin cnt_tick[0] = bcd_inc(cnt[0]); c = 1'b0; end
        end
        if (c) begin
            if (cnt[1] >= 8'h59) cnt_tick[1] = 8'h00;
            else begin cnt_tick[1] = bcd_inc(cnt[1]); c = 1'b0; end
        end
        if (c) begin
            if (cnt[2] >= 8'h23) cnt_tick[2] = 8'h00;
            else begin cnt_tick[2] = bcd_inc(cnt[2]); c = 1'b0; end
        end
        if (c) begin
            cnt_tick[3] = (cnt[3] >= 8'h07) ? 8'h01 : cnt[3] + 8'h01;
            if (cnt[4] >= last_day(cnt[5][4:0], cnt[6])) cnt_tick[4] = 8'h01;
            else begin cnt_tick[4] = bcd_inc(cnt[4]); c = 1'b0; end
        end
        if (c) begin
            if (cnt[5][4:0] >= 5'h12) cnt_tick[5] = {cnt[5][7:5], 5'h01};
            else begin
                cnt_tick[5] = {cnt[5][7:5], bcd_inc({3'b000, cnt[5][4:0]})[4:0]};
                c = 1'b0;
            end
        end
        if (c) begin
            if (cnt[6] >= 8'h99) cnt_tick[6] = 8'h00;
            else begin cnt_tick[6] = bcd_inc(cnt[6]); c = 1'b0; end
        end
        if (c) begin
            cnt_tick[7] = (cnt[7] >= 8'h99) ? 8'h00 : bcd_inc(cnt[7]);
        end
    end

    always_comb begin
        cnt_next = cnt_tick;
        for (int i = 0; i < NUM_TIME; i++) begin
            if (ovl_en[i]) cnt_next[i] = ovl_val[i];
            if (wr && (wr_idx == 3'(i))) cnt_next[i] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= TIME_RST;
        else        cnt <= cnt_next;
    end

    AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[0] <= 8'h59) && (cnt[0][3:0] <= 4'd9)); // R3
    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[2] <= 8'h23); // R3
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && (ovl_en == '0) && (cnt[0] == 8'h59)) |=> (cnt[0] == 8'h00)); // R3
    AST_MONTH_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && (ovl_en == '0)) |=> (cnt[5][7:5] == $past(cnt[5][7:5]))); // R5

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [NUM_ALARM-1:0][7:0]  alarm,
    input  logic [NUM_ALARM-1:0][7:0]  field,
    output logic                       hit
);

    logic [NUM_ALARM-1:0] match;

    for (genvar g = 0; g < NUM_ALARM; g++) begin : g_field
        assign match[g] = alarm[g][7] || (alarm[g][6:0] == field[g][6:0]);
    end

    assign hit = tick && (&match);

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && alarm[0][7] && alarm[1][7] && alarm[2][7] && alarm[3][7]) |-> hit); // R9

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              irq
);

    localparam logic [3:0] A_STAT = 4'hE;
    localparam logic [3:0] A_CTRL = 4'hF;

    xfer_state_t state, state_nx;
    logic [NUM_TIME-1:0][7:0]  vis, cnt, cnt_tick, cnt_next;
    logic [NUM_TIME-1:0]       dirty;
    logic [NUM_ALARM-1:0][7:0] alarm;
    logic [7:0] ctrl;
    logic       flag, hit;

    logic in_map, time_wr, ctrl_wr, stat_rd, core_wr;
    logic [7:0] wr_masked;

    assign in_map    = (addr[ADDR_W-1:4] == '0);
    assign time_wr   = wr_en && in_map && (addr[3] == 1'b0);
    assign ctrl_wr   = wr_en && in_map && (addr[3:0] == A_CTRL);
    assign stat_rd   = rd_en && in_map && (addr[3:0] == A_STAT);
    assign core_wr   = time_wr && (state != ST_FROZEN);
    assign wr_masked = wdata & time_mask(addr[2:0]);

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1s),
        .wr       (core_wr),
        .wr_idx   (addr[2:0]),
        .wr_val   (wr_masked),
        .ovl_en   ((state == ST_COMMIT) ? dirty : '0),
        .ovl_val  (vis),
        .cnt      (cnt),
        .cnt_tick (cnt_tick),
        .cnt_next (cnt_next)
    );

    rtc_alarm_unit u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1s),
        .alarm (alarm),
        .field ({cnt_tick[4], cnt_tick[2], cnt_tick[1], cnt_tick[0]}),
        .hit   (hit)
    );

    // transfer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LIVE:   if (ctrl_wr && !wdata[7]) state_nx = ST_FROZEN;
            ST_FROZEN: if (ctrl_wr &&  wdata[7]) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_LIVE;
        endcase
    end

    // outputs: visible copy, dirty marks, control, alarm, flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis   <= TIME_RST;
            dirty <= '0;
            alarm <= '0;
            ctrl  <= 8'h80;
            flag  <= 1'b0;
        end else begin
            unique case (state)
                ST_FROZEN: begin
                    if (time_wr) begin
                        vis[addr[2:0]]   <= wr_masked;
                        dirty[addr[2:0]] <= 1'b1;
                    end
                end
                ST_LIVE, ST_COMMIT: begin
                    vis   <= cnt_next;
                    dirty <= '0;
                end
            endcase
            if (ctrl_wr) ctrl <= wdata;
            if (wr_en && in_map && (addr[3:2] == 2'b10)) alarm[addr[1:0]] <= wdata;
            if (hit)          flag <= 1'b1;
            else if (stat_rd) flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (in_map) begin
            if (addr[3] == 1'b0)              rdata = vis[addr[2:0]];
            else if (addr[3:2] == 2'b10)      rdata = alarm[addr[1:0]];
            else if (addr[3:0] == A_STAT)     rdata = {7'b0, flag};
            else if (addr[3:0] == A_CTRL)     rdata = ctrl;
        end
    end

    assign irq = flag && ctrl[3];

    AST_COMMIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state == ST_LIVE)); // R7
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && !wr_en) |=> $stable(vis)); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !hit) |=> !flag); // R10
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R8

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rtc_bcd_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // strobed read (clears flag when a == 0xE)
    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); addr = a; rd_en = 1'b1; #1;
        check(req, rdata, exp);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(8'h02, h); wr(8'h01, m); wr(8'h00, s);
    endtask

    task automatic t_reset();
        logic [7:0] exp [0:7] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20};
        for (int i = 0; i < 8; i++) rd_chk(8'(i), exp[i], "R1 time reset");
        for (int i = 8; i < 12; i++) rd_chk(8'(i), 8'h00, "R1 alarm reset");
        rd_chk(8'h0E, 8'h00, "R1 status reset");
        rd_chk(8'h0F, 8'h80, "R1 control reset");
        check("R1 irq reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_mask();
        wr(8'h02, 8'hC5); rd_chk(8'h02, 8'h05, "R2 hour mask");
        wr(8'h00, 8'hB2); rd_chk(8'h00, 8'h32, "R2 sec mask");
        wr(8'h03, 8'hF3); rd_chk(8'h03, 8'h03, "R2 dow mask");
        wr(8'h06, 8'h47); rd_chk(8'h06, 8'h47, "R2 year full byte");
        wr(8'h05, 8'hE9); rd_chk(8'h05, 8'hE9, "R5 month ctl stored");
        rd_chk(8'h20, 8'h00, "R2 unmapped read");
    endtask

    task automatic t_rollover();
        wr(8'h07, 8'h20); wr(8'h06, 8'h99); wr(8'h05, 8'hB2);
        wr(8'h04, 8'h31); wr(8'h03, 8'h07);
        set_hms(8'h23, 8'h59, 8'h59);
        tick();
        rd_chk(8'h00, 8'h00, "R3 sec wrap");
        rd_chk(8'h01, 8'h00, "R3 min wrap");
        rd_chk(8'h02, 8'h00, "R3 hour wrap");
        rd_chk(8'h03, 8'h01, "R4 dow wrap");
        rd_chk(8'h04, 8'h01, "R4 date wrap");
        rd_chk(8'h05, 8'hA1, "R5 month wrap keeps ctl");
        rd_chk(8'h06, 8'h00, "R4 year wrap");
        rd_chk(8'h07, 8'h21, "R4 century carry");
    endtask

    task automatic t_leap();
        wr(8'h06, 8'h24); wr(8'h05, 8'h02); wr(8'h04, 8'h28);
        set_hms(8'h23, 8'h59, 8'h59); tick();
        rd_chk(8'h04, 8'h29, "R4 leap feb 29");
        set_hms(8'h23, 8'h59, 8'h59); tick();
        rd_chk(8'h04, 8'h01, "R4 leap feb end");
        rd_chk(8'h05, 8'h03, "R4 leap to march");
        wr(8'h06, 8'h23); wr(8'h05, 8'h02); wr(8'h04, 8'h28);
        set_hms(8'h23, 8'h59, 8'h59); tick();
        rd_chk(8'h04, 8'h01, "R4 common feb end");
        rd_chk(8'h05, 8'h03, "R4 common to march");
        wr(8'h05, 8'h04); wr(8'h04, 8'h30);
        set_hms(8'h23, 8'h59, 8'h59); tick();
        rd_chk(8'h04, 8'h01, "R4 30-day month");
        rd_chk(8'h05, 8'h05, "R4 april to may");
    endtask

    task automatic t_freeze();
        wr(8'h00, 8'h10); wr(8'h01, 8'h00);
        wr(8'h0F, 8'h00);
        tick(); tick(); tick();
        rd_chk(8'h00, 8'h10, "R6 frozen sec");
        wr(8'h01, 8'h45);
        rd_chk(8'h01, 8'h45, "R6 frozen write visible");
        wr(8'h0F, 8'h80);
        @(negedge clk);
        rd_chk(8'h00, 8'h13, "R7 no seconds lost");
        rd_chk(8'h01, 8'h45, "R7 frozen write committed");
    endtask

    task automatic t_alarm();
        wr(8'h0F, 8'h88);
        wr(8'h04, 8'h15); set_hms(8'h08, 8'h10, 8'h05);
        wr(8'h08, 8'h07); wr(8'h09, 8'h10); wr(8'h0A, 8'h08); wr(8'h0B, 8'h80);
        rd_chk(8'h0E, 8'h00, "R8 flag clear before");
        tick();
        check("R8 no match yet irq", {7'b0, irq}, 8'h00);
        tick();
        check("R11 irq on match", {7'b0, irq}, 8'h01);
        rd_chk(8'h0E, 8'h01, "R8 flag on match");
        rd_chk(8'h0E, 8'h00, "R10 read clears flag");
        check("R10 irq after clear", {7'b0, irq}, 8'h00);
        wr(8'h09, 8'h11); wr(8'h00, 8'h05);
        tick(); tick();
        rd_chk(8'h0E, 8'h00, "R8 minute mismatch");
    endtask

    task automatic t_every_sec();
        wr(8'h0F, 8'h80);
        for (int i = 8; i < 12; i++) wr(8'(i), 8'h80);
        tick();
        check("R11 irq gated off", {7'b0, irq}, 8'h00);
        rd_chk(8'h0E, 8'h01, "R9 every tick first");
        tick();
        rd_chk(8'h0E, 8'h01, "R9 every tick second");
        @(negedge clk); addr = 8'h0E; rd_en = 1'b1; tick_1s = 1'b1; #1;
        check("R10 read during set", rdata, 8'h00);
        @(negedge clk); rd_en = 1'b0; tick_1s = 1'b0;
        rd_chk(8'h0E, 8'h01, "R10 set wins over clear");
    endtask

    task automatic t_write_tick();
        wr(8'h01, 8'h05); wr(8'h00, 8'h59);
        @(negedge clk); addr = 8'h00; wdata = 8'h30; wr_en = 1'b1; tick_1s = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_1s = 1'b0;
        rd_chk(8'h00, 8'h30, "R12 write wins");
        rd_chk(8'h01, 8'h06, "R12 carry applied");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_rollover();
        t_leap();
        t_freeze();
        t_alarm();
        t_every_sec();
        t_write_tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule